// File: doc/BRIEF.md
# Coprocessor Instruction Snooping Unit

This unit sits next to a host processor on a shared address and data bus and follows the host's instruction stream without taking part in it. Every instruction fetch the host makes is copied into a private mirror of the host's prefetch queue. A two-bit queue-status input from the host says when a byte leaves that queue. The unit decodes from its own copy, so it sees each byte at the moment the host consumes it rather than when it was fetched. A first byte whose five upper bits are 11011 marks a coprocessor instruction. The byte that follows it is split into a mode field, an operation field and a register/memory selector.

For a memory operand, the host computes the effective address and performs the first read itself. The unit latches the address and the data word from that read cycle. When the operand is longer than one 16-bit word, the unit raises a bus request. Once the grant arrives it reads the remaining words at consecutive even offsets, then lets the bus go. The finished instruction is presented with a one-cycle valid strobe, together with its fields, the captured address and the assembled operand.

The state machine has six states:
- IDLE waits for an escape byte.
- MODRM waits for the selector byte.
- WAIT_RD waits for the host's own operand read.
- REQ holds the bus request until grant.
- XFER reads the extra words.
- DONE presents the result for one cycle.

The transitions are:
- escape-taken: IDLE to MODRM.
- register-operand: MODRM to DONE.
- memory-operand: MODRM to WAIT_RD.
- flush-abort: MODRM or WAIT_RD to IDLE.
- restart: MODRM to MODRM on a new escape.
- drop-decode: MODRM to IDLE on a new non-escape first byte.
- single-word: WAIT_RD to DONE.
- multi-word: WAIT_RD to REQ.
- granted: REQ to XFER.
- last-word: XFER to DONE.
- retire: DONE to IDLE.

Top module: `coproc_snoop`

## Requirements
- R1: A byte taken with queue status "first byte" starts a decode only when its bits [7:3] equal 11011. Any other first byte produces no `ins_valid` for the bytes that follow it.
- R2: For the byte that follows an escape:
  - bits [7:6] are reported on `ins_mod`;
  - bits [5:3] are reported on `ins_op`;
  - bits [2:0] are reported on `ins_rm`;
  - bits [2:0] of the escape byte are reported on `ins_esc`.
- R3: Queue status `qstat` is encoded as follows:
  - 00: nothing taken;
  - 01: first byte taken;
  - 10: later byte taken;
  - 11: flush.

  Decoding uses the byte at the head of the mirror queue when it is taken. A take while the queue is empty is ignored.
- R4: While `rst_n` is low, `width_strap` is sampled.
  - When it is 1, the queue holds 6 bytes and each fetch appends `fetch_data[7:0]` and then `fetch_data[15:8]`.
  - When it is 0, the queue holds 4 bytes and each fetch appends only `fetch_data[7:0]`.

  Bytes that do not fit are dropped.
- R5: A mode field of 11 gives `ins_valid` in the cycle after the selector byte is taken. No bus request is made.
- R6: For any other mode, the strobe `host_rd` latches `bus_addr` into `ins_addr` and `bus_data` into operand word 0.
- R7: Operand length is decoded from escape bits [2:1]:
  - 00: 2 words;
  - 01: 1 word;
  - 10: 4 words;
  - 11: 5 words.

  A 1-word operand gives `ins_valid` in the cycle after `host_rd`, with no request.
- R8: A longer operand raises `bus_req` in the cycle after `host_rd`, and the request is held until `bus_gnt`. After the grant:
  - `dma_rd` drives `dma_addr` equal to the latched address plus 2×i for word i;
  - each `dma_ack` stores `bus_data` into `ins_operand[16i+15:16i]`;
  - `bus_req` drops, and `ins_valid` rises, in the cycle after the last `dma_ack`.
- R9: A flush empties the mirror queue and returns a decode in MODRM or WAIT_RD to idle. A flush after `bus_req` has risen does not stop the transfer.
- R10: `ins_valid` lasts one cycle. Operand bits above the operand's length read as zero.
- R11: After reset, `bus_req`, `dma_rd` and `ins_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; `width_strap` is sampled while it is low |
| width_strap | input | 1 | Bus-width sense line: 1 selects a 16-bit host, 0 an 8-bit host |
| fetch_valid | input | 1 | The host fetch cycle completes this cycle |
| fetch_data | input | 16 | Bytes fetched by the host, low byte first |
| qstat | input | 2 | Host queue status (see R3) |
| host_rd | input | 1 | The host's operand read completes this cycle |
| bus_addr | input | 20 | Address on the shared bus |
| bus_data | input | 16 | Data on the shared bus |
| bus_gnt | input | 1 | Bus grant to this unit |
| dma_ack | input | 1 | A word read by this unit is on `bus_data` |
| bus_req | output | 1 | Bus request |
| dma_rd | output | 1 | Read strobe driven while this unit owns the bus |
| dma_addr | output | 20 | Address of the current borrowed read |
| ins_valid | output | 1 | One-cycle strobe: instruction decoded and operand complete |
| ins_esc | output | 3 | Low three bits of the escape byte |
| ins_mod | output | 2 | Mode field |
| ins_op | output | 3 | Operation field of the selector byte |
| ins_rm | output | 3 | Register/memory selector |
| ins_addr | output | 20 | Captured operand address |
| ins_operand | output | 80 | Assembled operand, word 0 lowest |

## Verification
The bench aims at the queue capacity limit in each host width. A unit that ignored the strap, or pushed the upper byte in 8-bit mode, would decode the wrong byte as an escape or selector. It flushes in each decode state. A unit that did not empty the queue would decode stale bytes, and one that flushed after the request would leave the bus held with no data. It holds the grant back and checks that no read strobe appears early, and it runs operands of every length back to back. A unit that did not clear the upper operand words would show stale data after a long operand, and an off-by-one word counter would release the bus one word early or late.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
    localparam logic [1:0] QS_NONE  = 2'b00;
    localparam logic [1:0] QS_FIRST = 2'b01;
    localparam logic [1:0] QS_NEXT  = 2'b10;
    localparam logic [1:0] QS_FLUSH = 2'b11;
    localparam logic [4:0] ESC_TAG  = 5'b11011;

    typedef enum logic [2:0] {
        S_IDLE, S_MODRM, S_WAIT_RD, S_REQ, S_XFER, S_DONE
    } snp_state_t;

    // operand size in 16-bit words, from escape bits [2:1]
    function automatic logic [2:0] operand_words(input logic [2:0] esc);
        logic [2:0] w;
        unique case (esc[2:1])
            2'b00:   w = 3'd2;
            2'b01:   w = 3'd1;
            2'b10:   w = 3'd4;
            default: w = 3'd5;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/snoop_queue.sv
module snoop_queue #(
    parameter int DEPTH_WIDE   = 6,
    parameter int DEPTH_NARROW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wide,
    input  logic       push,
    input  logic [15:0] push_data,
    input  logic       pop,
    input  logic       flush,
    output logic [7:0] head,
    output logic       head_ok
);
    localparam int CW = $clog2(DEPTH_WIDE + 1);
    localparam logic [CW-1:0] CAP_W = CW'(DEPTH_WIDE);
    localparam logic [CW-1:0] CAP_N = CW'(DEPTH_NARROW);

    logic [7:0]    q   [DEPTH_WIDE];
    logic [7:0]    q_n [DEPTH_WIDE];
    logic [CW-1:0] cnt, cnt_n, cap;

    assign cap = wide ? CAP_W : CAP_N;

    always_comb begin
        q_n   = q;
        cnt_n = cnt;
        if (flush) begin
            cnt_n = '0;
        end else begin
            if (pop && cnt != '0) begin
                for (int i = 0; i < DEPTH_WIDE - 1; i++) q_n[i] = q[i+1];
                cnt_n = cnt - 1'b1;
            end
            if (push) begin
                if (cnt_n < cap) begin
                    q_n[cnt_n] = push_data[7:0];
                    cnt_n      = cnt_n + 1'b1;
                end
                if (wide && cnt_n < cap) begin
                    q_n[cnt_n] = push_data[15:8];
                    cnt_n      = cnt_n + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_n;

    always_ff @(posedge clk) q <= q_n;

    assign head    = q[0];
    assign head_ok = (cnt != '0);

    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= cap);
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_ok);
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
    import snoop_pkg::*;
#(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int MAXW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pop_first,
    input  logic               pop_next,
    input  logic               flush,
    input  logic [7:0]         head,
    input  logic               head_ok,
    input  logic               host_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_data,
    input  logic               bus_gnt,
    input  logic               dma_ack,
    output logic               bus_req,
    output logic               dma_rd,
    output logic [AW-1:0]      dma_addr,
    output logic               ins_valid,
    output logic [2:0]         ins_esc,
    output logic [1:0]         ins_mod,
    output logic [2:0]         ins_op,
    output logic [2:0]         ins_rm,
    output logic [AW-1:0]      ins_addr,
    output logic [MAXW*DW-1:0] ins_operand
);
    snp_state_t        state, nxt;
    logic [2:0]        esc_q;
    logic [7:0]        modrm_q;
    logic [AW-1:0]     addr_q;
    logic [MAXW*DW-1:0] opnd_q;
    logic [2:0]        idx_q, words;
    logic              take_first, take_next, is_esc;

    assign take_first = pop_first && head_ok;
    assign take_next  = pop_next && head_ok;
    assign is_esc     = (head[7:3] == ESC_TAG);
    assign words      = operand_words(esc_q);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (take_first && is_esc) nxt = S_MODRM;
            S_MODRM:   if (flush)           nxt = S_IDLE;
                       else if (take_first) nxt = is_esc ? S_MODRM : S_IDLE;
                       else if (take_next)  nxt = (head[7:6] == 2'b11) ? S_DONE : S_WAIT_RD;
            S_WAIT_RD: if (flush)           nxt = S_IDLE;
                       else if (host_rd)    nxt = (words == 3'd1) ? S_DONE : S_REQ;
            S_REQ:     if (bus_gnt) nxt = S_XFER;
            S_XFER:    if (dma_ack && idx_q == words - 3'd1) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esc_q   <= '0;
            modrm_q <= '0;
            addr_q  <= '0;
            opnd_q  <= '0;
            idx_q   <= '0;
        end else begin
            if ((state == S_IDLE || (state == S_MODRM && !flush)) && take_first && is_esc)
                esc_q <= head[2:0];
            if (state == S_MODRM && !flush && !take_first && take_next)
                modrm_q <= head;
            if (state == S_WAIT_RD && !flush && host_rd) begin
                addr_q         <= bus_addr;
                opnd_q         <= '0;
                opnd_q[DW-1:0] <= bus_data;
                idx_q          <= 3'd1;
            end
            if (state == S_XFER && dma_ack) begin
                opnd_q[idx_q*DW +: DW] <= bus_data;
                idx_q                  <= idx_q + 3'd1;
            end
        end
    end

    always_comb begin
        bus_req     = (state == S_REQ) || (state == S_XFER);
        dma_rd      = (state == S_XFER);
        dma_addr    = addr_q + AW'({idx_q, 1'b0});
        ins_valid   = (state == S_DONE);
        ins_esc     = esc_q;
        ins_mod     = modrm_q[7:6];
        ins_op      = modrm_q[5:3];
        ins_rm      = modrm_q[2:0];
        ins_addr    = addr_q;
        ins_operand = opnd_q;
    end

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !dma_rd) |=> bus_req);
    p_rd_after_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rd) |-> $past(bus_gnt));
    p_first_borrow_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rd) |-> dma_addr == ins_addr + AW'(2));
    p_release_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> ins_valid);
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> !ins_valid);
    p_reg_no_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_mod == 2'b11) |-> (!bus_req && !$past(bus_req)));
endmodule

// File: rtl/coproc_snoop.sv
module coproc_snoop
    import snoop_pkg::*;
#(
    parameter int AW           = 20,
    parameter int DW           = 16,
    parameter int MAXW         = 5,
    parameter int DEPTH_WIDE   = 6,
    parameter int DEPTH_NARROW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               width_strap,
    input  logic               fetch_valid,
    input  logic [15:0]        fetch_data,
    input  logic [1:0]         qstat,
    input  logic               host_rd,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_data,
    input  logic               bus_gnt,
    input  logic               dma_ack,
    output logic               bus_req,
    output logic               dma_rd,
    output logic [AW-1:0]      dma_addr,
    output logic               ins_valid,
    output logic [2:0]         ins_esc,
    output logic [1:0]         ins_mod,
    output logic [2:0]         ins_op,
    output logic [2:0]         ins_rm,
    output logic [AW-1:0]      ins_addr,
    output logic [MAXW*DW-1:0] ins_operand
);
    logic       wide_q;
    logic       pop_first, pop_next, flush;
    logic [7:0] head;
    logic       head_ok;

    // host width is sensed only while reset is held
    always_ff @(posedge clk)
        if (!rst_n) wide_q <= width_strap;

    assign pop_first = (qstat == QS_FIRST);
    assign pop_next  = (qstat == QS_NEXT);
    assign flush     = (qstat == QS_FLUSH);

    snoop_queue #(.DEPTH_WIDE(DEPTH_WIDE), .DEPTH_NARROW(DEPTH_NARROW)) u_queue (
        .clk(clk), .rst_n(rst_n), .wide(wide_q),
        .push(fetch_valid), .push_data(fetch_data),
        .pop(pop_first || pop_next), .flush(flush),
        .head(head), .head_ok(head_ok)
    );

    snoop_ctrl #(.AW(AW), .DW(DW), .MAXW(MAXW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pop_first(pop_first), .pop_next(pop_next), .flush(flush),
        .head(head), .head_ok(head_ok),
        .host_rd(host_rd), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_gnt(bus_gnt), .dma_ack(dma_ack),
        .bus_req(bus_req), .dma_rd(dma_rd), .dma_addr(dma_addr),
        .ins_valid(ins_valid), .ins_esc(ins_esc), .ins_mod(ins_mod),
        .ins_op(ins_op), .ins_rm(ins_rm), .ins_addr(ins_addr),
        .ins_operand(ins_operand)
    );
endmodule

// File: tb/tb_coproc_snoop.sv
module tb_coproc_snoop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        width_strap = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_data = '0;
    logic [1:0]  qstat = 2'b00;
    logic        host_rd = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_gnt = 1'b0;
    logic        dma_ack = 1'b0;
    logic        bus_req, dma_rd, ins_valid;
    logic [19:0] dma_addr, ins_addr;
    logic [2:0]  ins_esc, ins_op, ins_rm;
    logic [1:0]  ins_mod;
    logic [79:0] ins_operand;

    int n_chk = 0;
    int n_fail = 0;

    coproc_snoop dut (
        .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data), .qstat(qstat),
        .host_rd(host_rd), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_gnt(bus_gnt), .dma_ack(dma_ack),
        .bus_req(bus_req), .dma_rd(dma_rd), .dma_addr(dma_addr),
        .ins_valid(ins_valid), .ins_esc(ins_esc), .ins_mod(ins_mod),
        .ins_op(ins_op), .ins_rm(ins_rm), .ins_addr(ins_addr),
        .ins_operand(ins_operand)
    );

    always #4 clk = ~clk;

    // {escape byte, selector byte, operand address}
    localparam logic [35:0] VEC [6] = '{
        {8'hD9, 8'h06, 20'h12340},
        {8'hDF, 8'h45, 20'h0FFF0},
        {8'hDB, 8'h2E, 20'h3ABCD},
        {8'hDD, 8'h86, 20'h20000},
        {8'hD8, 8'hC3, 20'h00000},
        {8'hDA, 8'h97, 20'hFFFFE}
    };

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic wide);
        rst_n = 1'b0;
        width_strap = wide;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        width_strap = ~wide;
    endtask

    task automatic fetch(input logic [15:0] w);
        fetch_valid = 1'b1; fetch_data = w;
        step();
        fetch_valid = 1'b0;
    endtask

    task automatic take(input logic [1:0] code);
        qstat = code;
        step();
        qstat = 2'b00;
    endtask

    task automatic host_read(input logic [19:0] a, input logic [15:0] d);
        host_rd = 1'b1; bus_addr = a; bus_data = d;
        step();
        host_rd = 1'b0; bus_addr = '0; bus_data = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        // R11 reset state
        chk(!bus_req && !dma_rd && !ins_valid, "R11 reset outputs", {bus_req, dma_rd, ins_valid}, 0);

        // table walk, 16-bit host (R2 R6 R7 R8 R10 R5)
        for (int k = 0; k < 6; k++) begin
            logic [7:0]  e, m;
            logic [19:0] a;
            logic [15:0] d0, wd;
            logic [79:0] expop;
            int nw;
            e = VEC[k][35:28]; m = VEC[k][27:20]; a = VEC[k][19:0];
            nw = (e[2:1] == 2'b00) ? 2 : (e[2:1] == 2'b01) ? 1 : (e[2:1] == 2'b10) ? 4 : 5;
            fetch({m, e});
            take(2'b01);
            chk(!ins_valid, "R1 no strobe after escape", ins_valid, 0);
            take(2'b10);
            if (m[7:6] == 2'b11) begin
                chk(ins_valid && !bus_req, "R5 register operand done", {ins_valid, bus_req}, 2'b10);
                chk({ins_esc, ins_mod, ins_op, ins_rm} == {e[2:0], m}, "R2 fields",
                    {ins_esc, ins_mod, ins_op, ins_rm}, {e[2:0], m});
                step();
            end else begin
                chk(!ins_valid && !bus_req, "R6 waiting for host read", {ins_valid, bus_req}, 0);
                d0 = 16'h0ABC + 16'(k * 16'h1111);
                expop = '0;
                expop[15:0] = d0;
                host_read(a, d0);
                if (nw == 1) begin
                    chk(ins_valid && !bus_req, "R7 single word no request", {ins_valid, bus_req}, 2'b10);
                end else begin
                    chk(bus_req && !dma_rd, "R8 request before grant", {bus_req, dma_rd}, 2'b10);
                    bus_gnt = 1'b1;
                    step();
                    bus_gnt = 1'b0;
                    for (int i = 1; i < nw; i++) begin
                        chk(dma_rd && dma_addr == a + 20'(2 * i), "R8 borrowed read address",
                            {dma_rd, dma_addr}, {1'b1, a + 20'(2 * i)});
                        wd = 16'h5000 + 16'(k * 16) + 16'(i);
                        expop[i*16 +: 16] = wd;
                        bus_data = wd; dma_ack = 1'b1;
                        step();
                        dma_ack = 1'b0; bus_data = '0;
                        if (i < nw - 1) chk(bus_req, "R8 request held mid transfer", bus_req, 1);
                    end
                    chk(ins_valid && !bus_req, "R8 release after last word", {ins_valid, bus_req}, 2'b10);
                end
                chk(ins_operand == expop, "R10 operand assembled", ins_operand, expop);
                chk(ins_addr == a, "R6 captured address", ins_addr, a);
                chk({ins_esc, ins_mod, ins_op, ins_rm} == {e[2:0], m}, "R2 fields",
                    {ins_esc, ins_mod, ins_op, ins_rm}, {e[2:0], m});
                step();
                chk(!ins_valid, "R10 strobe one cycle", ins_valid, 0);
            end
        end

        // R1 non-escape first byte
        fetch({8'hC6, 8'hD0});
        take(2'b01);
        take(2'b10);
        chk(!ins_valid, "R1 non-escape ignored", ins_valid, 0);

        // R3 take from empty queue ignored
        take(2'b01);
        take(2'b10);
        chk(!ins_valid, "R3 empty take ignored", ins_valid, 0);

        // R4 16-bit depth 6, low byte first
        fetch({8'h22, 8'h11});
        fetch({8'h44, 8'h33});
        fetch({8'hC1, 8'hD9});
        for (int i = 0; i < 5; i++) take(2'b01);
        take(2'b10);
        chk(ins_valid && ins_rm == 3'd1 && ins_esc == 3'd1, "R4 six-byte queue",
            {ins_valid, ins_esc, ins_rm}, {1'b1, 3'd1, 3'd1});
        step();

        // R9 flush in MODRM empties queue
        fetch({8'hC1, 8'hD9});
        fetch({8'hC5, 8'hDD});
        take(2'b01);
        take(2'b11);
        take(2'b10);
        chk(!ins_valid, "R9 flush abandons decode", ins_valid, 0);
        fetch({8'hC2, 8'hD8});
        take(2'b01);
        take(2'b10);
        chk(ins_valid && ins_esc == 3'd0 && ins_rm == 3'd2, "R9 queue emptied by flush",
            {ins_valid, ins_esc, ins_rm}, {1'b1, 3'd0, 3'd2});
        step();

        // R9 flush in WAIT_RD
        fetch({8'h06, 8'hD9});
        take(2'b01);
        take(2'b10);
        take(2'b11);
        host_read(20'h01000, 16'h1234);
        chk(!bus_req && !ins_valid, "R9 flush before read drops decode", {bus_req, ins_valid}, 0);
        step();
        chk(!bus_req && !ins_valid, "R9 stays idle", {bus_req, ins_valid}, 0);

        // R9 flush after request does not stop; R8 grant delay
        fetch({8'h06, 8'hD9});
        take(2'b01);
        take(2'b10);
        host_read(20'h02000, 16'h7777);
        take(2'b11);
        chk(bus_req && !dma_rd, "R9 flush ignored after request", {bus_req, dma_rd}, 2'b10);
        step();
        step();
        chk(bus_req && !dma_rd, "R8 no read before grant", {bus_req, dma_rd}, 2'b10);
        bus_gnt = 1'b1;
        step();
        bus_gnt = 1'b0;
        chk(dma_rd && dma_addr == 20'h02002, "R8 read after grant", {dma_rd, dma_addr}, {1'b1, 20'h02002});
        bus_data = 16'h8888; dma_ack = 1'b1;
        step();
        dma_ack = 1'b0; bus_data = '0;
        chk(ins_valid && !bus_req && ins_operand == 80'h88887777, "R8 two-word completes",
            ins_operand, 80'h88887777);
        step();

        // R4 8-bit host: depth 4, upper fetch byte ignored
        do_reset(1'b0);
        chk(!bus_req && !dma_rd && !ins_valid, "R11 reset outputs narrow", {bus_req, dma_rd, ins_valid}, 0);
        fetch({8'hD9, 8'h11});
        fetch({8'hD9, 8'h22});
        fetch({8'hD9, 8'h33});
        fetch({8'h00, 8'hD9});
        fetch({8'h00, 8'hC1});
        for (int i = 0; i < 4; i++) take(2'b01);
        take(2'b10);
        chk(!ins_valid, "R4 fifth byte dropped in narrow mode", ins_valid, 0);
        fetch({8'hD9, 8'hC3});
        take(2'b10);
        chk(ins_valid && ins_rm == 3'd3 && ins_mod == 2'b11, "R4 narrow decode",
            {ins_valid, ins_mod, ins_rm}, {1'b1, 2'b11, 3'd3});
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule